// File: doc/BRIEF.md
# MMC Host Data FIFO Engine

This block is the data buffer between a processor register port and the byte stream of an MMC/SD card. It holds two byte rings of equal depth: one collects bytes that the processor writes and sends them to the card, and the other collects bytes from the card until the processor reads them. The processor reaches each ring through a single data register and can move 1, 2 or 4 bytes per access. Bytes are packed into the lanes of that access width, starting from the most significant lane.

A remaining-byte counter bounds each transfer. The counter is loaded with block length times block count when a transfer starts. A direction input picks which ring the card side serves. At most one byte crosses the card interface per clock, under a valid/ready handshake. Two service-request flags, one for each direction, tell an outside interrupt or DMA unit when the processor should act.

Top module: `mmc_data_fifo`

## Requirements
- R1: After reset both ring levels, the remaining-byte count, both request flags, `card_tx_valid`, `card_rx_ready` and the receive read data are all zero.
- R2: `reg_size` gives the access width: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. A receive read pops up to that many bytes. The first byte popped lands in the most significant lane of the access width (bits 8*N-1 down to 8*N-8), and each later byte lands one lane lower.
- R3: A receive read stops popping when the receive ring is empty. Lanes that it did not fill read as zero, and a read of an empty ring returns zero and leaves the level at zero.
- R4: A transmit write pushes up to N bytes, most significant lane of the access width first. Pushing stops when the ring holds DEPTH bytes, and the bytes that did not fit are lost.
- R5: With `to_card`=1, the head byte of the transmit ring goes to the card whenever the remaining count and the transmit level are both nonzero. Each accepted byte lowers both by one. While the count is zero, nothing is offered to the card.
- R6: With `to_card`=0, card bytes are accepted while the remaining count is nonzero and the receive level is below DEPTH. Each accepted byte lowers the count, raises the level and sets `rx_req`.
- R7: `xfer_start` loads the count with `blk_len`*`blk_cnt` only when the count is zero. At any other time it has no effect.
- R8: `tx_req` is high exactly when `to_card`=1, the count is nonzero and the transmit ring is empty. A transmit write therefore clears it on the next cycle.
- R9: A receive read made in a cycle with no card byte accepted clears `rx_req`.
- R10: A receive read and a card byte accepted in the same cycle both take effect, and the new level is the old level plus one minus the number of bytes popped.
- R11: Ring pointers wrap modulo DEPTH, and the byte order is kept across the wrap on both rings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_size | input | 2 | Access width code for register accesses |
| rxd_rd | input | 1 | Receive data register read strobe |
| rxd_rdata | output | 32 | Receive data, lane-packed, valid in the cycle of the strobe |
| txd_wr | input | 1 | Transmit data register write strobe |
| txd_wdata | input | 32 | Transmit data, lane-packed |
| to_card | input | 1 | Direction: 1 writes to the card, 0 reads from it |
| xfer_start | input | 1 | Load the remaining-byte count |
| blk_len | input | LEN_W | Block length in bytes |
| blk_cnt | input | CNT_W | Number of blocks |
| card_tx_data | output | 8 | Byte toward the card |
| card_tx_valid | output | 1 | Byte toward the card is offered |
| card_tx_ready | input | 1 | Card accepts the offered byte |
| card_rx_data | input | 8 | Byte from the card |
| card_rx_valid | input | 1 | Byte from the card is offered |
| card_rx_ready | output | 1 | Block accepts a card byte |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |
| tx_level | output | $clog2(DEPTH)+1 | Transmit ring occupancy |
| rx_level | output | $clog2(DEPTH)+1 | Receive ring occupancy |
| bytes_left | output | LEN_W+CNT_W | Remaining-byte count |

## Verification
The bench builds the block with its defaults: DEPTH 32, a 12-bit block length and a 16-bit block count. With 32 bytes of depth, a full ring comes from eight word writes or one short card burst, so the full-ring drop and the back-pressure on `card_rx_ready` are both exercised. Small length-times-count products, such as 6, 10, 40 and 32 bytes, push both rings' pointers past the wrap point inside a few hundred cycles. A 40-byte transfer also leaves bytes outstanding while the receive ring is full, which makes it possible to test a read and a card push landing in the same cycle.

// File: rtl/mmc_fifo_pkg.sv
package mmc_fifo_pkg;

  localparam int unsigned LANES = 4;

  typedef enum logic [1:0] {
    ACC_BYTE  = 2'd0,
    ACC_HALF  = 2'd1,
    ACC_WORD  = 2'd2,
    ACC_WORD2 = 2'd3
  } acc_size_e;

  // Number of bytes an access of the given width code moves.
  function automatic logic [2:0] acc_bytes(logic [1:0] sz);
    case (acc_size_e'(sz))
      ACC_BYTE: return 3'd1;
      ACC_HALF: return 3'd2;
      default:  return 3'd4;
    endcase
  endfunction

  // Smaller of the requested byte count and the bytes available.
  function automatic logic [2:0] clamp_take(logic [2:0] want, int avail);
    if (avail < int'(want)) return 3'(avail);
    return want;
  endfunction

  // Lane that the i-th byte of an n-byte access occupies (MSB lane first).
  function automatic logic [1:0] lane_for(logic [2:0] n, logic [1:0] i);
    return 2'(n - 3'd1 - {1'b0, i});
  endfunction

endpackage

// File: rtl/byte_ring.sv
module byte_ring #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned PORTS = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [$clog2(PORTS+1)-1:0]        push_n,
  input  logic [PORTS-1:0][7:0]             push_bytes,
  input  logic [$clog2(PORTS+1)-1:0]        pop_n,
  output logic [PORTS-1:0][7:0]             peek,
  output logic [$clog2(DEPTH):0]            level
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = PW + 1;
  localparam int unsigned NW = $clog2(PORTS + 1);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] wr_base;

  assign wr_base = rd_ptr + level[PW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      level  <= '0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else begin
      for (int i = 0; i < PORTS; i++) begin
        if (NW'(i) < push_n) mem[wr_base + PW'(i)] <= push_bytes[i];
      end
      rd_ptr <= rd_ptr + PW'(pop_n);
      level  <= level + CW'(push_n) - CW'(pop_n);
    end
  end

  always_comb begin
    for (int i = 0; i < PORTS; i++) peek[i] = mem[rd_ptr + PW'(i)];
  end
endmodule

// File: rtl/remain_counter.sv
module remain_counter #(
  parameter int unsigned W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)                       count <= '0;
    else if (load_en && count == '0)  count <= load_val;
    else if (dec && count != '0)      count <= count - W'(1);
  end
endmodule

// File: rtl/mmc_data_fifo.sv
module mmc_data_fifo
  import mmc_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LEN_W = 12,
  parameter int unsigned CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 reg_size,
  input  logic                       rxd_rd,
  output logic [31:0]                rxd_rdata,
  input  logic                       txd_wr,
  input  logic [31:0]                txd_wdata,
  input  logic                       to_card,
  input  logic                       xfer_start,
  input  logic [LEN_W-1:0]           blk_len,
  input  logic [CNT_W-1:0]           blk_cnt,
  output logic [7:0]                 card_tx_data,
  output logic                       card_tx_valid,
  input  logic                       card_tx_ready,
  input  logic [7:0]                 card_rx_data,
  input  logic                       card_rx_valid,
  output logic                       card_rx_ready,
  output logic                       tx_req,
  output logic                       rx_req,
  output logic [$clog2(DEPTH):0]     tx_level,
  output logic [$clog2(DEPTH):0]     rx_level,
  output logic [LEN_W+CNT_W-1:0]     bytes_left
);
  localparam int unsigned REM_W = LEN_W + CNT_W;
  localparam int unsigned NW    = $clog2(LANES + 1);

  // Named internal events, also observed by the checker.
  logic [2:0]             acc_n;
  logic [2:0]             rx_take;
  logic [2:0]             rx_pop_n;
  logic [2:0]             tx_push_n;
  logic [2:0]             tx_pop_n;
  logic [2:0]             rx_push_n;
  logic                   tx_fire;
  logic                   rx_fire;
  logic                   xfer_live;
  logic [REM_W-1:0]       load_val;
  logic [LANES-1:0][7:0]  rx_peek;
  logic [LANES-1:0][7:0]  tx_peek;
  logic [LANES-1:0][7:0]  tx_push_b;
  logic [LANES-1:0][7:0]  rx_push_b;

  assign acc_n     = acc_bytes(reg_size);
  assign rx_take   = clamp_take(acc_n, int'(rx_level));
  assign rx_pop_n  = rxd_rd ? rx_take : 3'd0;
  assign tx_push_n = txd_wr ? clamp_take(acc_n, int'(DEPTH) - int'(tx_level)) : 3'd0;

  // Receive data: i-th popped byte placed from the top lane downward.
  always_comb begin
    rxd_rdata = '0;
    for (int i = 0; i < LANES; i++) begin
      if (3'(i) < rx_take)
        rxd_rdata[8*int'(lane_for(acc_n, 2'(i))) +: 8] = rx_peek[i];
    end
  end

  // Transmit data: i-th pushed byte taken from the top lane downward.
  always_comb begin
    for (int i = 0; i < LANES; i++)
      tx_push_b[i] = txd_wdata[8*int'(lane_for(acc_n, 2'(i))) +: 8];
  end

  // Card side.
  assign xfer_live     = (bytes_left != '0);
  assign card_tx_valid = to_card && xfer_live && (tx_level != '0);
  assign card_tx_data  = tx_peek[0];
  assign tx_fire       = card_tx_valid && card_tx_ready;
  assign tx_pop_n      = {2'b00, tx_fire};

  assign card_rx_ready = !to_card && xfer_live && (int'(rx_level) < int'(DEPTH));
  assign rx_fire       = card_rx_ready && card_rx_valid;
  assign rx_push_n     = {2'b00, rx_fire};

  always_comb begin
    rx_push_b    = '0;
    rx_push_b[0] = card_rx_data;
  end

  assign load_val = REM_W'(blk_len) * REM_W'(blk_cnt);
  assign tx_req   = to_card && xfer_live && (tx_level == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)       rx_req <= 1'b0;
    else if (rx_fire) rx_req <= 1'b1;
    else if (rxd_rd)  rx_req <= 1'b0;
  end

  byte_ring #(.DEPTH(DEPTH), .PORTS(LANES)) u_tx_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_n     (NW'(tx_push_n)),
    .push_bytes (tx_push_b),
    .pop_n      (NW'(tx_pop_n)),
    .peek       (tx_peek),
    .level      (tx_level)
  );

  byte_ring #(.DEPTH(DEPTH), .PORTS(LANES)) u_rx_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_n     (NW'(rx_push_n)),
    .push_bytes (rx_push_b),
    .pop_n      (NW'(rx_pop_n)),
    .peek       (rx_peek),
    .level      (rx_level)
  );

  remain_counter #(.W(REM_W)) u_remain (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (xfer_start),
    .load_val (load_val),
    .dec      (tx_fire || rx_fire),
    .count    (bytes_left)
  );
endmodule

// File: rtl/mmc_data_fifo_chk.sv
module mmc_data_fifo_chk #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LEN_W = 12,
  parameter int unsigned CNT_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   xfer_start,
  input logic [LEN_W-1:0]       blk_len,
  input logic [CNT_W-1:0]       blk_cnt,
  input logic                   rxd_rd,
  input logic [31:0]            rxd_rdata,
  input logic [$clog2(DEPTH):0] rx_level,
  input logic [$clog2(DEPTH):0] tx_level,
  input logic [LEN_W+CNT_W-1:0] bytes_left,
  input logic                   tx_fire,
  input logic                   rx_fire,
  input logic                   rx_req,
  input logic                   card_tx_valid,
  input logic                   card_rx_ready
);
  localparam int unsigned REM_W = LEN_W + CNT_W;
  logic [REM_W-1:0] want_len;
  assign want_len = REM_W'(blk_len) * REM_W'(blk_cnt);

  a_r4_tx_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tx_level) <= int'(DEPTH));

  a_r6_rx_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rx_level) <= int'(DEPTH));

  a_r5_count_drops: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fire |=> bytes_left == $past(bytes_left) - REM_W'(1));

  a_r6_rx_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fire |=> rx_req);

  a_r7_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && bytes_left == '0) |=> bytes_left == $past(want_len));

  a_r7_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && bytes_left != '0 && !tx_fire && !rx_fire) |=> $stable(bytes_left));

  a_r3_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rxd_rd && rx_level == '0) |-> rxd_rdata == '0);

  a_r9_rx_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rxd_rd && !rx_fire) |=> !rx_req);

  a_r5_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(card_tx_valid && card_rx_ready));
endmodule

bind mmc_data_fifo mmc_data_fifo_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .xfer_start    (xfer_start),
  .blk_len       (blk_len),
  .blk_cnt       (blk_cnt),
  .rxd_rd        (rxd_rd),
  .rxd_rdata     (rxd_rdata),
  .rx_level      (rx_level),
  .tx_level      (tx_level),
  .bytes_left    (bytes_left),
  .tx_fire       (tx_fire),
  .rx_fire       (rx_fire),
  .rx_req        (rx_req),
  .card_tx_valid (card_tx_valid),
  .card_rx_ready (card_rx_ready)
);

// File: tb/test_mmc_data_fifo.sv
`timescale 1ns/1ps
module test_mmc_data_fifo;
  localparam int unsigned DEPTH = 32;
  localparam int unsigned LEN_W = 12;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned REM_W = LEN_W + CNT_W;
  localparam int unsigned LVL_W = $clog2(DEPTH) + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        reg_size = '0;
  logic              rxd_rd = 1'b0;
  logic [31:0]       rxd_rdata;
  logic              txd_wr = 1'b0;
  logic [31:0]       txd_wdata = '0;
  logic              to_card = 1'b0;
  logic              xfer_start = 1'b0;
  logic [LEN_W-1:0]  blk_len = '0;
  logic [CNT_W-1:0]  blk_cnt = '0;
  logic [7:0]        card_tx_data;
  logic              card_tx_valid;
  logic              card_tx_ready = 1'b0;
  logic [7:0]        card_rx_data = '0;
  logic              card_rx_valid = 1'b0;
  logic              card_rx_ready;
  logic              tx_req, rx_req;
  logic [LVL_W-1:0]  tx_level, rx_level;
  logic [REM_W-1:0]  bytes_left;

  always #2.5 clk = ~clk;

  mmc_data_fifo #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) i_mmc_data_fifo (
    .clk(clk), .rst_n(rst_n), .reg_size(reg_size), .rxd_rd(rxd_rd), .rxd_rdata(rxd_rdata),
    .txd_wr(txd_wr), .txd_wdata(txd_wdata), .to_card(to_card), .xfer_start(xfer_start),
    .blk_len(blk_len), .blk_cnt(blk_cnt), .card_tx_data(card_tx_data),
    .card_tx_valid(card_tx_valid), .card_tx_ready(card_tx_ready),
    .card_rx_data(card_rx_data), .card_rx_valid(card_rx_valid),
    .card_rx_ready(card_rx_ready), .tx_req(tx_req), .rx_req(rx_req),
    .tx_level(tx_level), .rx_level(rx_level), .bytes_left(bytes_left)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] rxq[$];
  logic [7:0] txq[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int acc_of(logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  task automatic start_xfer(int len, int cnt);
    @(negedge clk);
    blk_len = LEN_W'(len); blk_cnt = CNT_W'(cnt); xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    #1;
  endtask

  // Receive read compared against the bench's own byte queue.
  task automatic rd_word(logic [1:0] sz, string tag);
    logic [31:0] exp = '0;
    logic [31:0] got;
    int n = acc_of(sz);
    for (int i = 0; i < n; i++)
      if (rxq.size() > 0) exp[8*(n-1-i) +: 8] = rxq.pop_front();
    @(negedge clk);
    reg_size = sz; rxd_rd = 1'b1;
    #1 got = rxd_rdata;
    @(negedge clk);
    rxd_rd = 1'b0;
    #1;
    chk(tag, got, exp);
  endtask

  task automatic rd_with_push(logic [1:0] sz, logic [7:0] b, string tag);
    logic [31:0] exp = '0;
    logic [31:0] got;
    int n = acc_of(sz);
    for (int i = 0; i < n; i++)
      if (rxq.size() > 0) exp[8*(n-1-i) +: 8] = rxq.pop_front();
    @(negedge clk);
    reg_size = sz; rxd_rd = 1'b1; card_rx_valid = 1'b1; card_rx_data = b;
    #1 got = rxd_rdata;
    if (card_rx_ready) rxq.push_back(b);
    @(negedge clk);
    rxd_rd = 1'b0; card_rx_valid = 1'b0;
    #1;
    chk(tag, got, exp);
  endtask

  task automatic wr_word(logic [1:0] sz, logic [31:0] d);
    int n = acc_of(sz);
    for (int i = 0; i < n; i++)
      if (txq.size() < DEPTH) txq.push_back(d[8*(n-1-i) +: 8]);
    @(negedge clk);
    reg_size = sz; txd_wr = 1'b1; txd_wdata = d;
    @(negedge clk);
    txd_wr = 1'b0;
    #1;
  endtask

  task automatic feed_rx(int cycles, logic [7:0] base);
    logic [7:0] nxt = base;
    @(negedge clk);
    card_rx_valid = 1'b1;
    for (int k = 0; k < cycles; k++) begin
      card_rx_data = nxt;
      #1 if (card_rx_ready) begin rxq.push_back(nxt); nxt = nxt + 8'd1; end
      @(negedge clk);
    end
    card_rx_valid = 1'b0;
    #1;
  endtask

  task automatic drain_tx(int cycles, string tag);
    @(negedge clk);
    card_tx_ready = 1'b1;
    for (int k = 0; k < cycles; k++) begin
      #1 if (card_tx_valid) chk(tag, 32'(card_tx_data), 32'(txq.pop_front()));
      else chk({tag, " valid"}, 32'(card_tx_valid), 32'd1);
      @(negedge clk);
    end
    card_tx_ready = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk("R1 tx_level", 32'(tx_level), 0);
    chk("R1 rx_level", 32'(rx_level), 0);
    chk("R1 bytes_left", 32'(bytes_left), 0);
    chk("R1 tx_req", 32'(tx_req), 0);
    chk("R1 rx_req", 32'(rx_req), 0);
    chk("R1 card_tx_valid", 32'(card_tx_valid), 0);
    chk("R1 card_rx_ready", 32'(card_rx_ready), 0);
    chk("R1 rdata", rxd_rdata, 0);
  endtask

  task automatic t_rx_basic();
    to_card = 1'b0;
    start_xfer(6, 1);
    chk("R7 load 6", 32'(bytes_left), 6);
    feed_rx(6, 8'hA1);
    chk("R6 rx_level", 32'(rx_level), 6);
    chk("R6 bytes_left", 32'(bytes_left), 0);
    chk("R6 rx_req", 32'(rx_req), 1);
    chk("R6 ready low at zero count", 32'(card_rx_ready), 0);
    rd_word(2'd2, "R2 word read");
    chk("R9 rx_req cleared", 32'(rx_req), 0);
    chk("R2 level after word", 32'(rx_level), 2);
    rd_word(2'd0, "R2 byte read");
    rd_word(2'd1, "R3 partial half read");
    rd_word(2'd2, "R3 empty read");
    chk("R3 level stays 0", 32'(rx_level), 0);
  endtask

  task automatic t_load_ignored();
    start_xfer(10, 1);
    chk("R7 load 10", 32'(bytes_left), 10);
    start_xfer(3, 2);
    chk("R7 reload ignored", 32'(bytes_left), 10);
    feed_rx(12, 8'h10);
    chk("R6 stops at count", 32'(rx_level), 10);
    chk("R6 count zero", 32'(bytes_left), 0);
    rd_word(2'd3, "R2 size3 is word");
    rd_word(2'd2, "R2 word");
    rd_word(2'd1, "R2 half");
    chk("R3 drained", 32'(rx_level), 0);
  endtask

  task automatic t_rx_full_wrap();
    start_xfer(20, 2);
    chk("R7 load 40", 32'(bytes_left), 40);
    feed_rx(36, 8'h40);
    chk("R6 ring full", 32'(rx_level), DEPTH);
    chk("R6 count left", 32'(bytes_left), 8);
    chk("R6 ready low when full", 32'(card_rx_ready), 0);
    rd_word(2'd2, "R11 wrapped read");
    rd_with_push(2'd0, 8'hC7, "R10 read with push");
    chk("R10 level", 32'(rx_level), 28);
    chk("R10 count", 32'(bytes_left), 7);
    for (int j = 0; j < 7; j++) rd_word(2'd2, "R11 order");
    chk("R11 empty", 32'(rx_level), 0);
    feed_rx(7, 8'hD0);
    chk("R6 count done", 32'(bytes_left), 0);
    rd_word(2'd2, "R11 tail");
    rd_word(2'd2, "R3 tail partial");
    chk("R11 model empty", 32'(rxq.size()), 0);
  endtask

  task automatic t_tx_path();
    @(negedge clk);
    to_card = 1'b1;
    #1 chk("R8 no req at zero count", 32'(tx_req), 0);
    start_xfer(8, 1);
    chk("R8 req when empty", 32'(tx_req), 1);
    wr_word(2'd2, 32'h11223344);
    chk("R4 word push", 32'(tx_level), 4);
    chk("R8 write clears req", 32'(tx_req), 0);
    wr_word(2'd1, 32'hAAAA5566);
    wr_word(2'd0, 32'h12345677);
    chk("R4 mixed widths", 32'(tx_level), 7);
    drain_tx(7, "R5 card order");
    chk("R5 tx empty", 32'(tx_level), 0);
    chk("R5 count", 32'(bytes_left), 1);
    chk("R8 req again", 32'(tx_req), 1);
    wr_word(2'd0, 32'h00000088);
    drain_tx(1, "R5 last byte");
    chk("R5 count zero", 32'(bytes_left), 0);
    wr_word(2'd2, 32'hDEADBEEF);
    @(negedge clk);
    card_tx_ready = 1'b1;
    #1 chk("R5 no valid at zero count", 32'(card_tx_valid), 0);
    @(negedge clk);
    card_tx_ready = 1'b0;
    #1 chk("R5 level kept", 32'(tx_level), 4);
    chk("R8 no req at zero count", 32'(tx_req), 0);
  endtask

  task automatic t_tx_overflow();
    wr_word(2'd0, 32'h000000EE);
    for (int j = 0; j < 7; j++)
      wr_word(2'd2, {8'hA0 + 8'(j), 8'hB0 + 8'(j), 8'hC0 + 8'(j), 8'hD0 + 8'(j)});
    chk("R4 full", 32'(tx_level), DEPTH);
    wr_word(2'd2, 32'h01020304);
    chk("R4 drop when full", 32'(tx_level), DEPTH);
    start_xfer(32, 1);
    drain_tx(32, "R11 tx wrap order");
    chk("R11 tx empty", 32'(tx_level), 0);
    chk("R5 count zero", 32'(bytes_left), 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_rx_basic();
    t_load_ignored();
    t_rx_full_wrap();
    t_tx_path();
    t_tx_overflow();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule